// File: doc/BRIEF.md
# 1-Wire Byte Controller with Interrupts

This block is the byte layer that sits between a host and the bit-timing engine of a 1-Wire bus master. The host writes bytes into a transmit buffer. Each byte moves into a transmit shift register and goes out as eight single-bit time slots, least-significant bit first. The bit that the engine samples in each slot is shifted into a receive shift register. After eight slots the received byte moves into a receive buffer. A byte is read from the bus by sending 0xFF and letting the slave pull bits low. A control bit asks the engine for a bus reset. The presence sample that the engine returns when the reset slot ends is kept as status.

Eight status flags cover the buffers, the shift registers, the presence result and two line conditions (line held low, line shorted). The two line conditions arrive as single-cycle strobes. An interrupt-enable register gives each interrupting flag its own enable. A master enable in the control register gates the single interrupt output.

Top module: `onewire_ctrl`

## Requirements
- R1: There are four host registers, selected by `reg_addr`: 0 data, 1 flags, 2 interrupt enable, 3 control. Read data is combinational from `reg_addr`. After reset the data register reads 0x00, flags read 0x0C, the enable register reads 0x00 and control reads 0x00. Bit 1 of the enable register ignores writes and reads 0.
- R2: The flags and enable registers share one bit layout: 7 line-low, 6 short, 5 receive-shift-full, 4 receive-buffer-full, 3 transmit-shift-empty, 2 transmit-buffer-empty, 0 presence. `irq` is 1 exactly when the master enable is 1 and some flag with its enable bit set is 1. Flags bit 1 holds the presence result and is never an interrupt source.
- R3: Clearing an enable bit removes that flag from `irq` and leaves the flag itself unchanged.
- R4: Control bit 0 is the master enable, reset to 0. While it is 0, `irq` stays 0.
- R5: A write to the data register clears transmit-buffer-empty in the next cycle. When the shift register is empty, the byte moves into it on the following cycle: transmit-buffer-empty sets and transmit-shift-empty clears. Transmit-shift-empty sets again when the eighth slot of the byte completes.
- R6: Each byte goes out as eight bit slots (`slot_kind` = 0), least-significant bit first, with the bit on `slot_wbit`. A request holds `slot_valid`, `slot_kind` and `slot_wbit` steady until `slot_ready` is 1. Bytes written back to back go out in write order.
- R7: Each completed bit slot shifts `slot_rbit` into the receive shift register, least-significant bit first. The eighth one moves the byte into the receive buffer and sets receive-buffer-full and receive-shift-full.
- R8: Reading the data register returns the receive buffer and clears receive-buffer-full.
- R9: Line-low, short, receive-shift-full and presence are sticky. Writing 1 to their bit in the flags register clears them. Writing 0 leaves them unchanged.
- R10: Writing 1 to control bit 1 issues a reset slot (`slot_kind` = 1), which takes priority over pending bit slots. When that slot completes, flags bit 1 takes the value of `slot_rbit`, and the presence flag (bit 0) sets if `slot_rbit` is 1. Before the slot completes, the presence flag does not set.
- R11: A one-cycle pulse on `line_low_evt` or `line_short_evt` sets flags bit 7 or bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_re | input | 1 | Host register read strobe (read side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data |
| irq | output | 1 | Combined interrupt |
| slot_valid | output | 1 | Slot request to the timing engine |
| slot_ready | input | 1 | Engine accepts the request |
| slot_kind | output | 1 | 0 bit slot, 1 reset slot |
| slot_wbit | output | 1 | Bit to send in a bit slot |
| slot_done | input | 1 | Engine finished the accepted slot |
| slot_rbit | input | 1 | Sampled bit, or presence result for a reset slot |
| line_low_evt | input | 1 | Line-held-low strobe |
| line_short_evt | input | 1 | Line-short strobe |

## Verification
The bench uses the package default of 8-bit registers and bytes. This keeps the interrupt decision small enough to sweep completely: every enable value, each with the master enable off and on, against a fixed mix of set and clear flags. A model of the timing engine in the bench accepts each request and answers with the sent bit ANDed with a slave byte. It runs byte patterns with isolated end bits, all ones and all zeros, two bytes back to back, and reset slots with and without presence.

// File: rtl/onewire_pkg.sv
// Package: shared widths, register selects, slot kinds and flag bit positions
// for the 1-Wire byte controller. Assumes 8-bit host registers.
package onewire_pkg;
    localparam int REG_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_FLAGS = 2'd1,
        SEL_IEN   = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        KIND_BIT   = 1'b0,
        KIND_RESET = 1'b1
    } slot_kind_e;

    localparam int FB_LOW     = 7;
    localparam int FB_SHORT   = 6;
    localparam int FB_RSFULL  = 5;
    localparam int FB_RBFULL  = 4;
    localparam int FB_TSEMPTY = 3;
    localparam int FB_TBEMPTY = 2;
    localparam int FB_PRESRES = 1;
    localparam int FB_PRES    = 0;

    localparam logic [REG_W-1:0] IEN_MASK = 8'hFD;
endpackage

// File: rtl/onewire_txseq.sv
// Transmit buffer, transmit shift register and slot sequencer.
// Issues one request at a time; reset requests win over bit slots.
// Assumes the engine pulses slot_done once per accepted request.
module onewire_txseq
    import onewire_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    input  logic          rst_req,
    output logic          slot_valid,
    input  logic          slot_ready,
    output logic          slot_kind,
    output logic          slot_wbit,
    input  logic          slot_done,
    input  logic          slot_rbit,
    output logic          tbuf_empty,
    output logic          tsr_empty,
    output logic          bit_evt,
    output logic          pres_evt,
    output logic          rx_val
);
    localparam int CNT_W = $clog2(DW);

    typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_e;

    seq_e             state;
    slot_kind_e       kind_q;
    logic [DW-1:0]    tbuf, tsr;
    logic             tbuf_full, tsr_full, rst_pend;
    logic [CNT_W-1:0] cnt;
    logic             load, finishing;

    // Move the buffered byte into the shifter whenever the shifter is idle.
    assign load      = tbuf_full && !tsr_full;
    assign finishing = (state == SQ_WAIT) && slot_done;

    // Buffer, shifter and sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            kind_q    <= KIND_BIT;
            tbuf      <= '0;
            tsr       <= '0;
            tbuf_full <= 1'b0;
            tsr_full  <= 1'b0;
            rst_pend  <= 1'b0;
            cnt       <= '0;
        end else begin
            if (wr_byte) tbuf <= wr_data;
            tbuf_full <= wr_byte || (tbuf_full && !load);
            if (load) begin
                tsr      <= tbuf;
                tsr_full <= 1'b1;
                cnt      <= '0;
            end
            case (state)
                SQ_IDLE: begin
                    if (rst_pend) begin
                        kind_q <= KIND_RESET;
                        state  <= SQ_REQ;
                    end else if (tsr_full) begin
                        kind_q <= KIND_BIT;
                        state  <= SQ_REQ;
                    end
                end
                SQ_REQ: if (slot_ready) state <= SQ_WAIT;
                SQ_WAIT: begin
                    if (slot_done) begin
                        state <= SQ_IDLE;
                        if (kind_q == KIND_RESET) begin
                            rst_pend <= 1'b0;
                        end else begin
                            tsr <= tsr >> 1;
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(DW-1)) tsr_full <= 1'b0;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
            if (rst_req) rst_pend <= 1'b1;
        end
    end

    // Request and completion signals toward the engine and the rest of the block.
    always_comb begin
        slot_valid = (state == SQ_REQ);
        slot_kind  = kind_q;
        slot_wbit  = tsr[0];
        tbuf_empty = !tbuf_full;
        tsr_empty  = !tsr_full;
        bit_evt    = finishing && (kind_q == KIND_BIT);
        pres_evt   = finishing && (kind_q == KIND_RESET);
        rx_val     = slot_rbit;
    end
endmodule

// File: rtl/onewire_rxpath.sv
// Receive shift register and receive buffer. Shifts sampled bits in
// LSB first; on the last bit of a byte the byte lands in the buffer.
// Assumes bit_evt is a single-cycle pulse per completed bit slot.
module onewire_rxpath #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_evt,
    input  logic          bit_val,
    input  logic          restart,
    input  logic          rd_ack,
    output logic [DW-1:0] rbuf,
    output logic          rbf,
    output logic          byte_evt
);
    localparam int CNT_W = $clog2(DW);

    logic [DW-1:0]    rsr, rsr_next;
    logic [CNT_W-1:0] cnt;

    // Next shift value and end-of-byte detection.
    always_comb begin
        rsr_next = {bit_val, rsr[DW-1:1]};
        byte_evt = bit_evt && (cnt == CNT_W'(DW-1));
    end

    // Shift register, bit counter and buffer with its full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsr  <= '0;
            cnt  <= '0;
            rbuf <= '0;
            rbf  <= 1'b0;
        end else begin
            if (restart) cnt <= '0;
            if (bit_evt) begin
                rsr <= rsr_next;
                cnt <= cnt + 1'b1;
            end
            if (byte_evt) rbuf <= rsr_next;
            rbf <= byte_evt || (rbf && !rd_ack);
        end
    end
endmodule

// File: rtl/onewire_irq.sv
// Status flags, interrupt-enable register, master enable and the
// combined interrupt. Sticky flags clear on write-one; set wins.
// Assumes condition flags (buffer/shifter state) come in as levels.
module onewire_irq
    import onewire_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic             men_we,
    input  logic             w1c_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             set_low,
    input  logic             set_short,
    input  logic             set_rsf,
    input  logic             pres_evt,
    input  logic             pres_val,
    input  logic             rbf,
    input  logic             tsr_empty,
    input  logic             tbuf_empty,
    output logic [REG_W-1:0] flags,
    output logic [REG_W-1:0] ien,
    output logic             men,
    output logic             irq
);
    logic             low_q, short_q, rsf_q, pd_q, pres_res_q;
    logic [REG_W-1:0] clr;

    // Write-one-to-clear mask.
    assign clr = w1c_we ? wdata : '0;

    // Enable registers and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien        <= '0;
            men        <= 1'b0;
            low_q      <= 1'b0;
            short_q    <= 1'b0;
            rsf_q      <= 1'b0;
            pd_q       <= 1'b0;
            pres_res_q <= 1'b0;
        end else begin
            if (ien_we) ien <= wdata & IEN_MASK;
            if (men_we) men <= wdata[0];
            low_q   <= set_low   || (low_q   && !clr[FB_LOW]);
            short_q <= set_short || (short_q && !clr[FB_SHORT]);
            rsf_q   <= set_rsf   || (rsf_q   && !clr[FB_RSFULL]);
            pd_q    <= (pres_evt && pres_val) || (pd_q && !clr[FB_PRES]);
            if (pres_evt) pres_res_q <= pres_val;
        end
    end

    // Flag vector in enable-register layout and the gated interrupt.
    always_comb begin
        flags             = '0;
        flags[FB_LOW]     = low_q;
        flags[FB_SHORT]   = short_q;
        flags[FB_RSFULL]  = rsf_q;
        flags[FB_RBFULL]  = rbf;
        flags[FB_TSEMPTY] = tsr_empty;
        flags[FB_TBEMPTY] = tbuf_empty;
        flags[FB_PRESRES] = pres_res_q;
        flags[FB_PRES]    = pd_q;
        irq               = men && |(flags & ien);
    end
endmodule

// File: rtl/onewire_ctrl.sv
// Top of the 1-Wire byte controller: host register decode and read mux,
// wiring of transmit sequencer, receive path and interrupt logic.
// Assumes the host holds reg_re for one cycle per read with side effects.
module onewire_ctrl
    import onewire_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              slot_valid,
    input  logic              slot_ready,
    output logic              slot_kind,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit,
    input  logic              line_low_evt,
    input  logic              line_short_evt
);
    reg_sel_e         sel;
    logic             wr_data, wr_flags, wr_ien, wr_ctrl, rd_data;
    logic             tbuf_empty, tsr_empty, bit_evt, pres_evt, rx_val;
    logic             rbf, byte_evt, men_q;
    logic [REG_W-1:0] rbuf, flag_vec, ien_q;

    // Register select decode.
    always_comb begin
        sel      = reg_sel_e'(reg_addr);
        wr_data  = reg_we && (sel == SEL_DATA);
        wr_flags = reg_we && (sel == SEL_FLAGS);
        wr_ien   = reg_we && (sel == SEL_IEN);
        wr_ctrl  = reg_we && (sel == SEL_CTRL);
        rd_data  = reg_re && (sel == SEL_DATA);
    end

    onewire_txseq #(.DW(REG_W)) i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_byte    (wr_data),
        .wr_data    (reg_wdata),
        .rst_req    (wr_ctrl && reg_wdata[1]),
        .slot_valid (slot_valid),
        .slot_ready (slot_ready),
        .slot_kind  (slot_kind),
        .slot_wbit  (slot_wbit),
        .slot_done  (slot_done),
        .slot_rbit  (slot_rbit),
        .tbuf_empty (tbuf_empty),
        .tsr_empty  (tsr_empty),
        .bit_evt    (bit_evt),
        .pres_evt   (pres_evt),
        .rx_val     (rx_val)
    );

    onewire_rxpath #(.DW(REG_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_evt  (bit_evt),
        .bit_val  (rx_val),
        .restart  (pres_evt),
        .rd_ack   (rd_data),
        .rbuf     (rbuf),
        .rbf      (rbf),
        .byte_evt (byte_evt)
    );

    onewire_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ien_we     (wr_ien),
        .men_we     (wr_ctrl),
        .w1c_we     (wr_flags),
        .wdata      (reg_wdata),
        .set_low    (line_low_evt),
        .set_short  (line_short_evt),
        .set_rsf    (byte_evt),
        .pres_evt   (pres_evt),
        .pres_val   (rx_val),
        .rbf        (rbf),
        .tsr_empty  (tsr_empty),
        .tbuf_empty (tbuf_empty),
        .flags      (flag_vec),
        .ien        (ien_q),
        .men        (men_q),
        .irq        (irq)
    );

    // Host read data mux.
    always_comb begin
        case (sel)
            SEL_DATA:  reg_rdata = rbuf;
            SEL_FLAGS: reg_rdata = flag_vec;
            SEL_IEN:   reg_rdata = ien_q;
            default:   reg_rdata = {{(REG_W-1){1'b0}}, men_q};
        endcase
    end
endmodule

// File: rtl/onewire_ctrl_chk.sv
// Checker for onewire_ctrl: temporal properties on ports and internal
// hand-off signals. Attached to every instance through bind.
module onewire_ctrl_chk
    import onewire_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq,
    input logic              men,
    input logic              slot_valid,
    input logic              slot_ready,
    input logic              slot_kind,
    input logic              slot_wbit,
    input logic [REG_W-1:0]  flags,
    input logic              pres_evt,
    input logic              bit_evt
);
    a_r4_irq_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> men);

    a_r6_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_kind) && $stable(slot_wbit)));

    a_r5_write_clears_tbe: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd0) |=> !flags[FB_TBEMPTY]);

    a_r10_presence_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FB_PRES]) |-> $past(pres_evt));

    a_r7_rbf_from_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FB_RBFULL]) |-> $past(bit_evt));

    a_r1_reserved_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd2) |-> !reg_rdata[FB_PRESRES]);
endmodule

bind onewire_ctrl onewire_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq        (irq),
    .men        (men_q),
    .slot_valid (slot_valid),
    .slot_ready (slot_ready),
    .slot_kind  (slot_kind),
    .slot_wbit  (slot_wbit),
    .flags      (flag_vec),
    .pres_evt   (pres_evt),
    .bit_evt    (bit_evt)
);

// File: tb/test_onewire_ctrl.sv
module test_onewire_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0, reg_re = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, slot_valid, slot_kind, slot_wbit;
    logic       slot_ready = 1'b0, slot_done = 1'b0, slot_rbit = 1'b0;
    logic       line_low_evt = 1'b0, line_short_evt = 1'b0;

    int         n_checks = 0;
    int         n_errors = 0;
    bit         finished = 1'b0;

    logic [15:0] sent_bits;
    int          bit_idx = 0;
    int          n_reset_slots = 0;
    logic [7:0]  slave_byte = 8'hFF;
    logic        pres_resp = 1'b0;

    always #2.5 clk = ~clk;

    onewire_ctrl i_onewire_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .slot_valid(slot_valid), .slot_ready(slot_ready),
        .slot_kind(slot_kind), .slot_wbit(slot_wbit), .slot_done(slot_done),
        .slot_rbit(slot_rbit), .line_low_evt(line_low_evt),
        .line_short_evt(line_short_evt)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_re = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic wait_flag(input int pos, input string req);
        logic [7:0] f;
        f = 8'h00;
        for (int i = 0; i < 400; i++) begin
            reg_read(2'd1, f);
            if (f[pos]) break;
        end
        chk(req, {7'd0, f[pos]}, 8'h01);
    endtask

    // Model of the bit-timing engine: accepts a request, answers later.
    initial begin
        forever begin
            @(negedge clk);
            slot_done = 1'b0;
            if (slot_valid) begin
                if (slot_kind) begin
                    n_reset_slots++;
                    slot_rbit = pres_resp;
                end else begin
                    sent_bits[bit_idx] = slot_wbit;
                    slot_rbit = slot_wbit & slave_byte[bit_idx % 8];
                    bit_idx++;
                end
                slot_ready = 1'b1;
                @(negedge clk);
                slot_ready = 1'b0;
                repeat (2) @(negedge clk);
                slot_done = 1'b1;
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] d, f;
        logic [7:0] pat [6] = '{8'hA5, 8'h3C, 8'h01, 8'h80, 8'hFF, 8'h00};
        logic [7:0] slv [6] = '{8'hFF, 8'h0F, 8'hFF, 8'hFF, 8'h5A, 8'hFF};
        int rs0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R4 reset state
        reg_read(2'd0, d); chk("R1 data reset", d, 8'h00);
        reg_read(2'd1, d); chk("R1 flags reset", d, 8'h0C);
        reg_read(2'd2, d); chk("R1 enable reset", d, 8'h00);
        reg_read(2'd3, d); chk("R4 control reset", d, 8'h00);
        chk("R4 irq reset", {7'd0, irq}, 8'h00);

        // R1 reserved enable bit
        reg_write(2'd2, 8'hFF);
        reg_read(2'd2, d); chk("R1 enable readback", d, 8'hFD);
        reg_write(2'd2, 8'h00);

        // R5 R6 R7 R8 R9 single bytes
        for (int k = 0; k < 6; k++) begin
            bit_idx = 0;
            slave_byte = slv[k];
            reg_write(2'd0, pat[k]);
            reg_read(2'd1, f);
            chk("R5 tbe cleared by write", {6'd0, f[3], f[2]}, 8'h02);
            reg_read(2'd1, f);
            chk("R5 byte moved to shifter", {6'd0, f[3], f[2]}, 8'h01);
            wait_flag(4, "R7 receive buffer full");
            chk("R6 bits LSB first", sent_bits[7:0], pat[k]);
            reg_read(2'd1, f);
            chk("R5 both tx empties set", {6'd0, f[3], f[2]}, 8'h03);
            chk("R7 receive shift full", {7'd0, f[5]}, 8'h01);
            reg_read(2'd0, d);
            chk("R7 received byte", d, pat[k] & slv[k]);
            reg_read(2'd1, f);
            chk("R8 read clears rbf", {7'd0, f[4]}, 8'h00);
            reg_write(2'd1, 8'h00);
            reg_read(2'd1, f);
            chk("R9 write zero keeps rsf", {7'd0, f[5]}, 8'h01);
            reg_write(2'd1, 8'h20);
            reg_read(2'd1, f);
            chk("R9 write one clears rsf", {7'd0, f[5]}, 8'h00);
        end

        // R6 back-to-back bytes keep order
        bit_idx = 0;
        slave_byte = 8'hFF;
        reg_write(2'd0, 8'h96);
        reg_write(2'd0, 8'h4E);
        wait_flag(4, "R7 first byte arrives");
        reg_read(2'd0, d); chk("R6 first byte", d, 8'h96);
        wait_flag(4, "R7 second byte arrives");
        reg_read(2'd0, d); chk("R6 second byte", d, 8'h4E);
        chk("R6 sixteen bits in order", sent_bits[15:8], 8'h4E);
        reg_write(2'd1, 8'h20);

        // R10 reset slot with presence
        pres_resp = 1'b1;
        rs0 = n_reset_slots;
        reg_write(2'd3, 8'h02);
        reg_read(2'd1, f);
        chk("R10 presence not before slot end", {7'd0, f[0]}, 8'h00);
        wait_flag(0, "R10 presence flag sets");
        reg_read(2'd1, f);
        chk("R10 presence result bit", {7'd0, f[1]}, 8'h01);
        chk("R10 one reset slot issued", 8'(n_reset_slots - rs0), 8'h01);
        reg_read(2'd3, d); chk("R4 reset request does not set master", d, 8'h00);

        // R10 reset slot without presence
        pres_resp = 1'b0;
        reg_write(2'd1, 8'h01);
        reg_read(2'd1, f); chk("R9 presence cleared", {7'd0, f[0]}, 8'h00);
        reg_write(2'd3, 8'h02);
        repeat (20) @(negedge clk);
        reg_read(2'd1, f);
        chk("R10 no presence flag", {7'd0, f[0]}, 8'h00);
        chk("R10 result bit cleared", {7'd0, f[1]}, 8'h00);

        // Presence back on for the sweep
        pres_resp = 1'b1;
        reg_write(2'd3, 8'h02);
        wait_flag(0, "R10 presence flag sets again");

        // R11 line strobes
        line_low_evt = 1'b1; @(negedge clk); line_low_evt = 1'b0;
        reg_read(2'd1, f); chk("R11 line low flag", {7'd0, f[7]}, 8'h01);
        line_short_evt = 1'b1; @(negedge clk); line_short_evt = 1'b0;
        reg_read(2'd1, f); chk("R11 short flag", {7'd0, f[6]}, 8'h01);

        // R2 R3 R4 gating
        reg_write(2'd2, 8'h40);
        reg_write(2'd3, 8'h01);
        chk("R2 enabled short raises irq", {7'd0, irq}, 8'h01);
        reg_write(2'd2, 8'h00);
        chk("R3 disabled source drops irq", {7'd0, irq}, 8'h00);
        reg_read(2'd1, f); chk("R3 flag kept", {7'd0, f[6]}, 8'h01);
        reg_write(2'd2, 8'h40);
        reg_write(2'd3, 8'h00);
        chk("R4 master off masks irq", {7'd0, irq}, 8'h00);
        reg_write(2'd1, 8'h40);

        // R2 exhaustive sweep over enables and master enable
        reg_read(2'd1, f);
        chk("R2 sweep flag mix", f, 8'h8F);
        for (int e = 0; e < 256; e++) begin
            for (int m = 0; m < 2; m++) begin
                reg_write(2'd2, 8'(e));
                reg_write(2'd3, 8'(m));
                chk("R2 irq sweep", {7'd0, irq},
                    {7'd0, (m == 1) && ((f & 8'(e) & 8'hFD) != 8'h00)});
            end
        end

        finish_run();
    end
endmodule